// File: doc/BRIEF.md
# UART receiver with RTS flow control

This block is the receive half of an asynchronous serial port. A deserializer recovers 8N1 characters (one start bit, eight data bits sent least significant bit first, one stop bit) from the serial line. It runs off a 16x oversampling tick and hands each good character to a six-entry receive FIFO. The host pops that FIFO one byte per read strobe. An active-low ready-to-send output, `rts_n`, tells the far end to pause while the FIFO is filling up. It tells the far end to resume once the host has drained the FIFO.

Two one-cycle task strobes control reception. `task_start` turns the receiver on and signals ready at once. `task_stop` signals not-ready and opens a drain window of four character times. Characters already in flight still land during that window. When the window ends, a receive-timeout event fires and the receiver switches off.

A per-byte data-ready event and the timeout event each set a pending bit. The interrupt line is the OR of the pending bits that are enabled. The enables are changed through separate write-one-to-set and write-one-to-clear strobes, so the host can mask data-ready while the FIFO and flow control keep working.

Top module: `uart_rx_flow`

## Requirements
- R1: While the receiver is on, an 8N1 character on `rx_i` that is sampled at mid-bit from `os_tick` (16 ticks per bit, data LSB first, stop bit 1) is pushed to the FIFO. `rd_valid` is 1 exactly when the FIFO holds data, and `rd_data` shows the oldest byte.
- R2: A character whose stop bit samples 0 is discarded and sets the sticky `frame_err`. `frame_err` is cleared only by a pulse on `flag_clr[1]`.
- R3: The FIFO holds 6 bytes in arrival order. Each `rd_strobe` pops exactly one byte, and a `rd_strobe` with the FIFO empty changes nothing.
- R4: A character that completes while the FIFO is full is dropped, and the stored bytes are kept. This sets the sticky `overrun`, which is cleared only by a pulse on `flag_clr[0]`.
- R5: While running, a push that leaves 4 or fewer free entries (occupancy 2 or more) drives `rts_n` to 1 on the next clock edge. The push and the change of `rts_n` happen together.
- R6: Once `rts_n` has gone to 1 for occupancy, it returns to 0 only in the cycle when the FIFO becomes empty. Popping down to a non-zero occupancy leaves it at 1.
- R7: `task_start` drives `rts_n` to 0 in the following cycle whatever the FIFO occupancy. `rts_n` then stays 0 until a later push reaches the threshold. `task_start` wins over a simultaneous `task_stop`.
- R8: `task_stop` drives `rts_n` to 1 in the following cycle. `rts_n` stays 1 until the next `task_start`, even if the FIFO is emptied.
- R9: After `task_stop` while running, `ev_timeout` pulses for one cycle after 640 `os_tick` periods (4 characters of 10 bits). Characters that complete within that window still enter the FIFO. After the pulse, the line is ignored. A `task_start` inside the window cancels the pulse.
- R10: `ev_rxrdy` pulses once per byte accepted into the FIFO. Pending bits are bit 0 for data-ready and bit 1 for timeout, and are set by the events and cleared by `pend_clr`. Enables are set by `ien_set` and cleared by `ien_clr`. `irq` is the OR of enabled pending bits, and clearing enable bit 0 masks data-ready while the FIFO and `rts_n` keep operating.
- R11: After reset: `rts_n`=1, `rd_valid`=0, `irq`=0, both error flags 0, all enables 0. The receiver is off, so characters on the line are ignored until `task_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | 16x oversampling enable, one cycle wide |
| rx_i | input | 1 | Serial receive line, idle high |
| task_start | input | 1 | Start-receive strobe |
| task_stop | input | 1 | Stop-receive strobe |
| rd_strobe | input | 1 | Pop one byte from the FIFO |
| rd_data | output | 8 | Oldest byte in the FIFO |
| rd_valid | output | 1 | FIFO not empty |
| rts_n | output | 1 | Ready-to-send, active low |
| ev_rxrdy | output | 1 | One-cycle pulse per byte accepted |
| ev_timeout | output | 1 | One-cycle receive-timeout pulse |
| ien_set | input | 2 | Write-one-to-set interrupt enables |
| ien_clr | input | 2 | Write-one-to-clear interrupt enables |
| pend_clr | input | 2 | Write-one-to-clear pending events |
| irq | output | 1 | Masked interrupt |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 overrun, bit 1 framing |
| overrun | output | 1 | Sticky FIFO overrun flag |
| frame_err | output | 1 | Sticky framing error flag |

## Verification
The bench targets the hysteresis band: it pops from two bytes to one, where a level-based design would drop `rts_n` too early. It also fires `task_start` with a full FIFO, where a design that let occupancy win would leave the far end stalled. It drives a stop-then-send case to catch a receiver that shuts off at the stop strobe and loses the in-flight byte. A restart inside the drain window catches a timer that is never cancelled. Overrun, framing errors and masked data-ready are driven so that a design that corrupted stored bytes, kept a bad character or let a masked event reach `irq` shows it at the ports.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {RX_OFF, RX_RUN, RX_DRAIN} rx_mode_e;
  typedef enum logic [1:0] {DS_IDLE, DS_START, DS_DATA, DS_STOP} ds_state_e;
  localparam int NUM_SRC = 2;
  localparam int SRC_RDY = 0;
  localparam int SRC_TMO = 1;
  localparam int ERR_OVR = 0;
  localparam int ERR_FRM = 1;
endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser import uart_rx_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              os_tick,
  input  logic              rx_i,
  output logic              byte_valid,
  output logic [DATA_W-1:0] byte_data,
  output logic              frame_bad
);
  localparam int CW = $clog2(OVS);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  ds_state_e         state;
  logic [CW-1:0]     ovs_cnt;
  logic [BW-1:0]     bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              rx_s1, rx_s2, rx_prev;

  assign byte_data = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= DS_IDLE;
      ovs_cnt    <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      byte_valid <= 1'b0;
      frame_bad  <= 1'b0;
      rx_s1      <= 1'b1;
      rx_s2      <= 1'b1;
      rx_prev    <= 1'b1;
    end else begin
      rx_s1      <= rx_i;
      rx_s2      <= rx_s1;
      byte_valid <= 1'b0;
      frame_bad  <= 1'b0;
      if (os_tick) rx_prev <= rx_s2;
      if (!enable) begin
        state <= DS_IDLE;
      end else if (os_tick) begin
        case (state)
          DS_IDLE: begin
            // a start bit is a falling edge, so a low line left by a bad stop bit is not taken
            if (rx_prev && !rx_s2) begin
              state   <= DS_START;
              ovs_cnt <= '0;
            end
          end
          DS_START: begin
            if (ovs_cnt == CW'(OVS/2 - 1)) begin
              ovs_cnt <= '0;
              bit_idx <= '0;
              state   <= rx_s2 ? DS_IDLE : DS_DATA;
            end else begin
              ovs_cnt <= ovs_cnt + 1'b1;
            end
          end
          DS_DATA: begin
            if (ovs_cnt == CW'(OVS - 1)) begin
              ovs_cnt <= '0;
              shreg   <= {rx_s2, shreg[DATA_W-1:1]};
              if (bit_idx == BW'(DATA_W - 1)) state <= DS_STOP;
              else bit_idx <= bit_idx + 1'b1;
            end else begin
              ovs_cnt <= ovs_cnt + 1'b1;
            end
          end
          default: begin
            if (ovs_cnt == CW'(OVS - 1)) begin
              ovs_cnt <= '0;
              state   <= DS_IDLE;
              if (rx_s2) byte_valid <= 1'b1;
              else       frame_bad  <= 1'b1;
            end else begin
              ovs_cnt <= ovs_cnt + 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [DATA_W-1:0]          push_data,
  input  logic                       pop,
  output logic [DATA_W-1:0]          head,
  output logic [$clog2(DEPTH+1)-1:0] occ,
  output logic                       empty,
  output logic                       push_ok,
  output logic                       pop_ok,
  output logic                       drop
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              full;

  assign full    = (occ == CNT_W'(DEPTH));
  assign empty   = (occ == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign drop    = push && full;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_flow_ctrl.sv
module uart_rx_flow_ctrl import uart_rx_pkg::*; #(
  parameter int DEPTH     = 6,
  parameter int HIGH_OCC  = 2,
  parameter int TMO_TICKS = 640
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       task_start,
  input  logic                       task_stop,
  input  logic                       os_tick,
  input  logic                       push_ok,
  input  logic                       pop_ok,
  input  logic [$clog2(DEPTH+1)-1:0] occ,
  output rx_mode_e                   mode,
  output logic                       rts_n,
  output logic                       tmo_pulse
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int TW    = $clog2(TMO_TICKS+1);

  logic [CNT_W:0] occ_next;
  logic [TW-1:0]  tmo_cnt;

  always_comb begin
    occ_next = {1'b0, occ} + (CNT_W+1)'(push_ok) - (CNT_W+1)'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= RX_OFF;
      rts_n     <= 1'b1;
      tmo_cnt   <= '0;
      tmo_pulse <= 1'b0;
    end else begin
      tmo_pulse <= 1'b0;
      if (task_start) begin
        mode    <= RX_RUN;
        rts_n   <= 1'b0;
        tmo_cnt <= '0;
      end else if (task_stop) begin
        rts_n <= 1'b1;
        if (mode == RX_RUN) begin
          mode    <= RX_DRAIN;
          tmo_cnt <= '0;
        end
      end else begin
        case (mode)
          RX_RUN: begin
            // raise on a push that reaches the mark, release only on empty
            if (push_ok && occ_next >= (CNT_W+1)'(HIGH_OCC)) rts_n <= 1'b1;
            else if (rts_n && occ_next == '0)                 rts_n <= 1'b0;
          end
          RX_DRAIN: begin
            if (os_tick) begin
              if (tmo_cnt == TW'(TMO_TICKS - 1)) begin
                tmo_pulse <= 1'b1;
                mode      <= RX_OFF;
                tmo_cnt   <= '0;
              end else begin
                tmo_cnt <= tmo_cnt + 1'b1;
              end
            end
          end
          default: rts_n <= 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_flow.sv
module uart_rx_flow import uart_rx_pkg::*; #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 6,
  parameter int FREE_THR   = 4,
  parameter int OVS        = 16,
  parameter int CHAR_BITS  = 10,
  parameter int TMO_CHARS  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               os_tick,
  input  logic               rx_i,
  input  logic               task_start,
  input  logic               task_stop,
  input  logic               rd_strobe,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid,
  output logic               rts_n,
  output logic               ev_rxrdy,
  output logic               ev_timeout,
  input  logic [NUM_SRC-1:0] ien_set,
  input  logic [NUM_SRC-1:0] ien_clr,
  input  logic [NUM_SRC-1:0] pend_clr,
  output logic               irq,
  input  logic [1:0]         flag_clr,
  output logic               overrun,
  output logic               frame_err
);
  localparam int HIGH_OCC  = FIFO_DEPTH - FREE_THR;
  localparam int TMO_TICKS = TMO_CHARS * CHAR_BITS * OVS;
  localparam int CNT_W     = $clog2(FIFO_DEPTH+1);

  rx_mode_e           mode;
  logic               byte_valid, frame_bad;
  logic [DATA_W-1:0]  byte_data;
  logic [CNT_W-1:0]   occ;
  logic               empty, push_ok, pop_ok, drop, tmo_pulse;
  logic [NUM_SRC-1:0] ien, pend, src_evt;

  uart_rx_deser #(.DATA_W(DATA_W), .OVS(OVS)) u_deser (
    .clk(clk), .rst(rst), .enable(mode != RX_OFF), .os_tick(os_tick), .rx_i(rx_i),
    .byte_valid(byte_valid), .byte_data(byte_data), .frame_bad(frame_bad)
  );

  uart_rx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(byte_valid), .push_data(byte_data), .pop(rd_strobe),
    .head(rd_data), .occ(occ), .empty(empty), .push_ok(push_ok), .pop_ok(pop_ok),
    .drop(drop)
  );

  uart_rx_flow_ctrl #(.DEPTH(FIFO_DEPTH), .HIGH_OCC(HIGH_OCC), .TMO_TICKS(TMO_TICKS)) u_ctrl (
    .clk(clk), .rst(rst), .task_start(task_start), .task_stop(task_stop),
    .os_tick(os_tick), .push_ok(push_ok), .pop_ok(pop_ok), .occ(occ),
    .mode(mode), .rts_n(rts_n), .tmo_pulse(tmo_pulse)
  );

  assign rd_valid   = !empty;
  assign ev_timeout = tmo_pulse;

  always_comb begin
    src_evt          = '0;
    src_evt[SRC_RDY] = push_ok;
    src_evt[SRC_TMO] = tmo_pulse;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien       <= '0;
      pend      <= '0;
      irq       <= 1'b0;
      ev_rxrdy  <= 1'b0;
      overrun   <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      ien       <= (ien | ien_set) & ~ien_clr;
      pend      <= (pend & ~pend_clr) | src_evt;
      irq       <= |(pend & ien);
      ev_rxrdy  <= push_ok;
      overrun   <= (overrun   & ~flag_clr[ERR_OVR]) | drop;
      frame_err <= (frame_err & ~flag_clr[ERR_FRM]) | frame_bad;
    end
  end
endmodule

// File: rtl/uart_rx_flow_chk.sv
module uart_rx_flow_chk #(
  parameter int DEPTH = 6,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             task_start,
  input logic             task_stop,
  input logic             rts_n,
  input logic             rd_valid,
  input logic             ev_rxrdy,
  input logic             ev_timeout,
  input logic [1:0]       flag_clr,
  input logic             overrun,
  input logic             frame_err,
  input logic [CNT_W-1:0] occ
);
  p_start_ready_r7: assert property (@(posedge clk) disable iff (rst)
    task_start |=> !rts_n);

  p_stop_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
    (task_stop && !task_start) |=> rts_n);

  p_release_on_empty_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(rts_n) |-> (!rd_valid || $past(task_start)));

  p_fifo_bound_r3: assert property (@(posedge clk) disable iff (rst)
    occ <= CNT_W'(DEPTH));

  p_overrun_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (overrun && !flag_clr[0]) |=> overrun);

  p_frame_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (frame_err && !flag_clr[1]) |=> frame_err);

  p_timeout_single_r9: assert property (@(posedge clk) disable iff (rst)
    ev_timeout |=> !ev_timeout);

  p_rdy_has_data_r10: assert property (@(posedge clk) disable iff (rst)
    ev_rxrdy |-> rd_valid);
endmodule

bind uart_rx_flow uart_rx_flow_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .task_start(task_start), .task_stop(task_stop),
  .rts_n(rts_n), .rd_valid(rd_valid), .ev_rxrdy(ev_rxrdy), .ev_timeout(ev_timeout),
  .flag_clr(flag_clr), .overrun(overrun), .frame_err(frame_err), .occ(occ)
);

// File: tb/test_uart_rx_flow.sv
module test_uart_rx_flow;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;
  localparam int DEPTH      = 6;
  localparam int TMO_CLKS   = 640 * TICK_DIV;

  logic       clk = 1'b0, rst = 1'b1, os_tick = 1'b0, rx_i = 1'b1;
  logic       task_start = 1'b0, task_stop = 1'b0, rd_strobe = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid, rts_n, ev_rxrdy, ev_timeout, irq, overrun, frame_err;
  logic [1:0] ien_set = '0, ien_clr = '0, pend_clr = '0, flag_clr = '0;

  int n_chk = 0, n_err = 0, cyc = 0, n_rdy = 0, n_tmo = 0, tmo_cyc = 0, stop_cyc = 0;
  bit done = 0;
  logic [7:0] q[$];
  bit exp_rts = 1'b0, exp_ovr = 1'b0;
  int exp_rdy = 0;

  uart_rx_flow i_uart_rx_flow (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_i(rx_i),
    .task_start(task_start), .task_stop(task_stop), .rd_strobe(rd_strobe),
    .rd_data(rd_data), .rd_valid(rd_valid), .rts_n(rts_n),
    .ev_rxrdy(ev_rxrdy), .ev_timeout(ev_timeout),
    .ien_set(ien_set), .ien_clr(ien_clr), .pend_clr(pend_clr), .irq(irq),
    .flag_clr(flag_clr), .overrun(overrun), .frame_err(frame_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      repeat (TICK_DIV - 1) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (ev_rxrdy) n_rdy <= n_rdy + 1;
      if (ev_timeout) begin
        n_tmo   <= n_tmo + 1;
        tmo_cyc <= cyc;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // bench model of the FIFO and the flow-control rules
  function automatic void model_push(input logic [7:0] b);
    if (q.size() < DEPTH) begin
      q.push_back(b);
      exp_rdy++;
      if (q.size() >= DEPTH - 4) exp_rts = 1'b1;
    end else begin
      exp_ovr = 1'b1;
    end
  endfunction

  function automatic void model_pop();
    if (q.size() > 0) begin
      void'(q.pop_front());
      if (exp_rts && q.size() == 0) exp_rts = 1'b0;
    end
  endfunction

  function automatic int model_head();
    return (q.size() > 0) ? int'(q[0]) : -1;
  endfunction

  task automatic send_frame(input logic [7:0] b, input logic stop_bit);
    @(negedge clk) rx_i = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_i = b[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    rx_i = stop_bit;
    repeat (BIT_CLKS) @(negedge clk);
    rx_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_start();
    @(negedge clk) task_start = 1'b1;
    @(negedge clk) task_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_stop();
    @(negedge clk) task_stop = 1'b1;
    stop_cyc = cyc;
    @(negedge clk) task_stop = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse2(input int which, input logic [1:0] v);
    @(negedge clk);
    case (which)
      0: ien_set  = v;
      1: ien_clr  = v;
      2: pend_clr = v;
      default: flag_clr = v;
    endcase
    @(negedge clk);
    ien_set = '0; ien_clr = '0; pend_clr = '0; flag_clr = '0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1357_2468));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11", "rts_n", rts_n, 1);
    chk("R11", "rd_valid", rd_valid, 0);
    chk("R11", "irq", irq, 0);
    chk("R11", "overrun", overrun, 0);
    chk("R11", "frame_err", frame_err, 0);
    send_frame(8'h3C, 1'b1);
    chk("R11", "rd_valid while off", rd_valid, 0);
    chk("R11", "rxrdy while off", n_rdy, 0);

    do_start();
    chk("R7", "rts_n after start", rts_n, 0);
    pulse2(0, 2'b01);
    send_frame(8'hA5, 1'b1); model_push(8'hA5);
    chk("R1", "rd_valid", rd_valid, 1);
    chk("R1", "rd_data", rd_data, 8'hA5);
    chk("R5", "rts_n one byte", rts_n, 0);
    chk("R10", "rxrdy count", n_rdy, 1);
    chk("R10", "irq enabled", irq, 1);
    send_frame(8'h5A, 1'b1); model_push(8'h5A);
    chk("R5", "rts_n at threshold", rts_n, 1);
    do_read(); model_pop();
    chk("R6", "rts_n one left", rts_n, 1);
    chk("R3", "head after pop", rd_data, 8'h5A);
    do_read(); model_pop();
    chk("R6", "rts_n empty", rts_n, 0);
    chk("R3", "rd_valid empty", rd_valid, 0);

    pulse2(2, 2'b01);
    pulse2(1, 2'b01);
    chk("R10", "irq cleared", irq, 0);
    send_frame(8'h11, 1'b1); model_push(8'h11);
    chk("R10", "irq masked", irq, 0);
    chk("R10", "rxrdy still counts", n_rdy, 3);
    send_frame(8'h22, 1'b1); model_push(8'h22);
    chk("R10", "rts_n acts while masked", rts_n, 1);
    send_frame(8'h33, 1'b1); model_push(8'h33);
    send_frame(8'h44, 1'b1); model_push(8'h44);
    send_frame(8'h55, 1'b1); model_push(8'h55);
    send_frame(8'h66, 1'b1); model_push(8'h66);
    chk("R4", "no overrun yet", overrun, 0);
    send_frame(8'h77, 1'b1); model_push(8'h77);
    chk("R4", "overrun set", overrun, 1);
    chk("R4", "head kept", rd_data, 8'h11);
    pulse2(3, 2'b01); exp_ovr = 1'b0;
    chk("R4", "overrun cleared", overrun, 0);

    do_start(); exp_rts = 1'b0;
    chk("R7", "rts_n start with full fifo", rts_n, 0);
    for (int k = 0; k < DEPTH; k++) begin
      chk("R3", "drain order", rd_data, model_head());
      do_read(); model_pop();
      chk("R7", "rts_n stays low draining", rts_n, 0);
    end
    chk("R3", "empty after drain", rd_valid, 0);
    do_read();
    chk("R3", "read on empty", rd_valid, 0);
    send_frame(8'h99, 1'b1); model_push(8'h99);
    chk("R3", "data after empty read", rd_data, 8'h99);
    do_read(); model_pop();

    send_frame(8'hF0, 1'b0);
    chk("R2", "frame_err set", frame_err, 1);
    chk("R2", "bad byte discarded", rd_valid, 0);
    pulse2(3, 2'b10);
    chk("R2", "frame_err cleared", frame_err, 0);

    do_stop();
    chk("R8", "rts_n after stop", rts_n, 1);
    send_frame(8'hC3, 1'b1);
    chk("R9", "in-flight byte lands", rd_data, 8'hC3);
    chk("R9", "in-flight valid", rd_valid, 1);
    do_read();
    chk("R8", "rts_n high while draining", rts_n, 1);
    for (int w = 0; w < TMO_CLKS + 200 && n_tmo == 0; w++) @(negedge clk);
    chk("R9", "one timeout", n_tmo, 1);
    chk("R9", "timeout delay ok", int'((tmo_cyc - stop_cyc) >= TMO_CLKS - 12 && (tmo_cyc - stop_cyc) <= TMO_CLKS + 12), 1);
    send_frame(8'h81, 1'b1);
    chk("R9", "line ignored after timeout", rd_valid, 0);

    do_start();
    do_stop();
    repeat (100 * TICK_DIV) @(negedge clk);
    do_start();
    repeat (TMO_CLKS + 400) @(negedge clk);
    chk("R9", "restart cancels timeout", n_tmo, 1);
    chk("R7", "rts_n after restart", rts_n, 0);

    q.delete(); exp_rts = 1'b0; exp_ovr = 1'b0; exp_rdy = n_rdy;
    for (int it = 0; it < 36; it++) begin
      int op = $urandom_range(0, 2);
      if (op != 0) begin
        logic [7:0] b = 8'($urandom);
        send_frame(b, 1'b1); model_push(b);
      end else begin
        do_read(); model_pop();
      end
      chk("R5", "random rts_n", rts_n, exp_rts);
      chk("R3", "random rd_valid", rd_valid, int'(q.size() > 0));
      if (q.size() > 0) chk("R1", "random head", rd_data, model_head());
      chk("R4", "random overrun", overrun, exp_ovr);
      if (exp_ovr) begin
        pulse2(3, 2'b01);
        exp_ovr = 1'b0;
      end
    end
    chk("R10", "rxrdy total", n_rdy, exp_rdy);
    finish_run();
  end
endmodule